// File: doc/BRIEF.md
# Error-Correction Engine Register Front End

This block is the register-facing shell of a NAND flash error-correction engine. Software uses a 32-bit register bus to configure the engine. It turns control bits on and off through dedicated set and clear addresses, programs two independent byte counts, and then streams payload and check bytes through a single data port, one byte per write. The block forwards each accepted byte to the attached codec and counts it. When the count reaches the programmed target for the current mode, it raises a sticky completion flag.

The polynomial arithmetic lives in a separate codec. The codec hands this block two things on side ports: its parity words, which software reads back as consecutive 32-bit words, and its correction verdict, which is captured into the status register when decoding completes. While decoding, the block also tracks whether every byte streamed since the last init was 0x00, or every byte was 0xFF. An erased or blank page can then be recognised without any correction work.

Top module: `ecc_reg_front`

## Requirements
- R1: After reset the control word (offset 0x00), the count word (0x0C) and the status word (0x24) all read zero.
- R2: Control bits are 0 enable, 1 init, 2 strong correction, 3 encode (0 = decode). A write to 0x04 ORs wdata[3:0] into them, a write to 0x08 clears the bits set in wdata[3:0], and a write to 0x00 changes nothing. Enable, strong and encode drive the codec outputs directly.
- R3: Offset 0x0C stores the encode target in bits 9:0 and the decode target in bits 25:16; all other bits read back as zero.
- R4: One cycle after init is set, the byte counter, the blank trackers and the whole status word are cleared, and init reads back as 0.
- R5: A write to the data port at 0x10 is accepted when enable is 1 and init is 0. The accepted byte wdata[7:0] appears on the codec byte output in the same cycle, with its valid strobe.
- R6: In encode mode, status bit 2 is set on the accepted byte that brings the count up to the encode target.
- R7: In decode mode, status bit 3 is set on the byte that reaches the decode target. In the same cycle the codec verdict is ORed into the status word: error present into bit 0, uncorrectable into bit 1, the 7-bit total into bits 22:16 and the 4-bit count into bits 31:28.
- R8: At decode completion, bit 5 is set if every byte since init was 0x00, and bit 4 is set if every byte was 0xFF.
- R9: Writing 0x24 clears exactly the status bits written as 1; other bits are kept.
- R10: Reading 0x14 + 4*i returns parity word i from the codec, bits 32*i+31 down to 32*i of its parity bus, so the first parity byte sits in the least significant byte.
- R11: Data port writes made while enable is 0 are not counted and set no completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| par_words_i | input | 32*PAR_WORDS | Parity words from the codec, word 0 lowest |
| res_err_i | input | 1 | Codec: errors were found |
| res_uncor_i | input | 1 | Codec: errors exceed the correction strength |
| res_total_i | input | 7 | Codec: total error count |
| res_count_i | input | 4 | Codec: reported error count |
| cdc_en | output | 1 | Engine enable to the codec |
| cdc_init | output | 1 | Init pulse to the codec |
| cdc_strong | output | 1 | Strong correction selected |
| cdc_encode | output | 1 | Encode mode selected |
| cdc_byte_vld | output | 1 | An accepted stream byte is present |
| cdc_byte | output | 8 | Stream byte |

## Verification
The bound checker watches several properties on every cycle. Init must drop after one cycle and must leave a zero byte counter. A disabled data write must leave the counter untouched. Each completion event must be followed by its sticky status bit, and the blank flags may rise only together with decode completion. The exact value of each field, the status word's value after complete encode and decode runs, the behaviour of partial write-one-to-clear, the placement of parity bytes and the rejection of writes to the plain control address are shown only by the bench. Its behavioural model predicts every readable register on every cycle, and directed scenarios cover blank, mixed and uncorrectable pages.

// File: rtl/ecc_front_pkg.sv
package ecc_front_pkg;
  // register offsets (byte addresses)
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_SET  = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int OFS_CNT  = 'h0C;
  localparam int OFS_DATA = 'h10;
  localparam int OFS_PAR  = 'h14;
  localparam int OFS_STAT = 'h24;

  // control bit positions
  localparam int CTL_W     = 4;
  localparam int CB_EN     = 0;
  localparam int CB_INIT   = 1;
  localparam int CB_STRONG = 2;
  localparam int CB_ENC    = 3;

  // status bit positions
  localparam int ST_ERR     = 0;
  localparam int ST_UNCOR   = 1;
  localparam int ST_ENCD    = 2;
  localparam int ST_DECD    = 3;
  localparam int ST_ONES    = 4;
  localparam int ST_ZERO    = 5;
  localparam int ST_TOT_LSB = 16;
  localparam int ST_TOT_W   = 7;
  localparam int ST_CNT_LSB = 28;
  localparam int ST_CNT_W   = 4;

  localparam int DEC_CNT_LSB = 16;

  typedef struct packed {
    logic                err;
    logic                uncor;
    logic [ST_TOT_W-1:0] total;
    logic [ST_CNT_W-1:0] count;
  } dec_result_t;

  function automatic logic [CTL_W-1:0] alias_update(logic [CTL_W-1:0] cur,
                                                    logic [CTL_W-1:0] set_m,
                                                    logic [CTL_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  function automatic logic [31:0] w1c_update(logic [31:0] cur, logic [31:0] clr_m,
                                             logic [31:0] set_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  function automatic logic [31:0] verdict_bits(dec_result_t r);
    logic [31:0] v;
    v = '0;
    v[ST_ERR]   = r.err;
    v[ST_UNCOR] = r.uncor;
    v[ST_TOT_LSB +: ST_TOT_W] = r.total;
    v[ST_CNT_LSB +: ST_CNT_W] = r.count;
    return v;
  endfunction
endpackage

// File: rtl/ecc_ctrl_bank.sv
module ecc_ctrl_bank
  import ecc_front_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [CTL_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  enc_cnt_q,
  output logic [CNT_W-1:0]  dec_cnt_q
);
  logic [CTL_W-1:0] set_m, clr_m, ctrl_nxt;
  logic             cnt_wr;

  always_comb begin
    set_m    = (we && addr == ADDR_W'(OFS_SET)) ? wdata[CTL_W-1:0] : '0;
    clr_m    = (we && addr == ADDR_W'(OFS_CLR)) ? wdata[CTL_W-1:0] : '0;
    ctrl_nxt = alias_update(ctrl_q, set_m, clr_m);
    if (ctrl_q[CB_INIT]) ctrl_nxt[CB_INIT] = 1'b0;
  end

  assign cnt_wr = we && addr == ADDR_W'(OFS_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      enc_cnt_q <= '0;
      dec_cnt_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (cnt_wr) begin
        enc_cnt_q <= wdata[CNT_W-1:0];
        dec_cnt_q <= wdata[DEC_CNT_LSB +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/ecc_stream_track.sv
module ecc_stream_track #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             accept,
  input  logic [7:0]       byte_in,
  input  logic             encode,
  input  logic [CNT_W-1:0] enc_cnt,
  input  logic [CNT_W-1:0] dec_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             evt_enc_done,
  output logic             evt_dec_done,
  output logic             blank_zero,
  output logic             blank_ones
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             zero_q, ones_q;

  assign cnt_nxt      = byte_cnt + CNT_W'(1);
  assign evt_enc_done = accept &&  encode && cnt_nxt == enc_cnt;
  assign evt_dec_done = accept && !encode && cnt_nxt == dec_cnt;
  assign blank_zero   = zero_q && byte_in == 8'h00;
  assign blank_ones   = ones_q && byte_in == 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      zero_q   <= 1'b1;
      ones_q   <= 1'b1;
    end else if (init) begin
      byte_cnt <= '0;
      zero_q   <= 1'b1;
      ones_q   <= 1'b1;
    end else if (accept) begin
      byte_cnt <= cnt_nxt;
      zero_q   <= blank_zero;
      ones_q   <= blank_ones;
    end
  end
endmodule

// File: rtl/ecc_status_w1c.sv
module ecc_status_w1c
  import ecc_front_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_we,
  input  logic [31:0] clr_mask,
  input  logic        init,
  input  logic        evt_enc_done,
  input  logic        evt_dec_done,
  input  logic        blank_zero,
  input  logic        blank_ones,
  input  dec_result_t result,
  output logic [31:0] status_q
);
  logic [31:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[ST_ENCD] = evt_enc_done;
    if (evt_dec_done) begin
      set_v          = set_v | verdict_bits(result);
      set_v[ST_DECD] = 1'b1;
      set_v[ST_ZERO] = blank_zero;
      set_v[ST_ONES] = blank_ones;
    end
    clr_v = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= '0;
    else if (init) status_q <= '0;
    else           status_q <= w1c_update(status_q, clr_v, set_v);
  end
endmodule

// File: rtl/ecc_reg_front.sv
module ecc_reg_front
  import ecc_front_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 10,
  parameter int PAR_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [32*PAR_WORDS-1:0] par_words_i,
  input  logic                   res_err_i,
  input  logic                   res_uncor_i,
  input  logic [6:0]             res_total_i,
  input  logic [3:0]             res_count_i,
  output logic                   cdc_en,
  output logic                   cdc_init,
  output logic                   cdc_strong,
  output logic                   cdc_encode,
  output logic                   cdc_byte_vld,
  output logic [7:0]             cdc_byte
);
  localparam int PAR_BITS = 32 * PAR_WORDS;

  logic [CTL_W-1:0] ctrl_q;
  logic [CNT_W-1:0] enc_cnt_q, dec_cnt_q, byte_cnt;
  logic [31:0]      status_q;
  logic             accept, evt_enc_done, evt_dec_done, blank_zero, blank_ones;
  dec_result_t      result;
  logic [PAR_WORDS-1:0][31:0] par_pick;
  logic [31:0]      par_rd;

  assign accept = bus_we && bus_addr == ADDR_W'(OFS_DATA)
                  && ctrl_q[CB_EN] && !ctrl_q[CB_INIT];

  assign result = '{err: res_err_i, uncor: res_uncor_i,
                    total: res_total_i, count: res_count_i};

  ecc_ctrl_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .enc_cnt_q(enc_cnt_q), .dec_cnt_q(dec_cnt_q)
  );

  ecc_stream_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .init(ctrl_q[CB_INIT]), .accept(accept),
    .byte_in(bus_wdata[7:0]), .encode(ctrl_q[CB_ENC]),
    .enc_cnt(enc_cnt_q), .dec_cnt(dec_cnt_q), .byte_cnt(byte_cnt),
    .evt_enc_done(evt_enc_done), .evt_dec_done(evt_dec_done),
    .blank_zero(blank_zero), .blank_ones(blank_ones)
  );

  ecc_status_w1c u_stat (
    .clk(clk), .rst_n(rst_n),
    .clr_we(bus_we && bus_addr == ADDR_W'(OFS_STAT)), .clr_mask(bus_wdata),
    .init(ctrl_q[CB_INIT]), .evt_enc_done(evt_enc_done),
    .evt_dec_done(evt_dec_done), .blank_zero(blank_zero),
    .blank_ones(blank_ones), .result(result), .status_q(status_q)
  );

  // one selector per parity word
  for (genvar g = 0; g < PAR_WORDS; g++) begin : g_par
    assign par_pick[g] = (bus_addr == ADDR_W'(OFS_PAR + 4 * g))
                         ? par_words_i[32*g +: 32] : 32'h0;
  end

  always_comb begin
    par_rd = '0;
    for (int i = 0; i < PAR_WORDS; i++) par_rd = par_rd | par_pick[i];
  end

  always_comb begin
    bus_rdata = par_rd;
    if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = 32'(ctrl_q);
    else if (bus_addr == ADDR_W'(OFS_CNT)) begin
      bus_rdata = '0;
      bus_rdata[CNT_W-1:0]             = enc_cnt_q;
      bus_rdata[DEC_CNT_LSB +: CNT_W]  = dec_cnt_q;
    end
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = status_q;
  end

  assign cdc_en       = ctrl_q[CB_EN];
  assign cdc_init     = ctrl_q[CB_INIT];
  assign cdc_strong   = ctrl_q[CB_STRONG];
  assign cdc_encode   = ctrl_q[CB_ENC];
  assign cdc_byte_vld = accept;
  assign cdc_byte     = accept ? bus_wdata[7:0] : 8'h00;

  logic unused_par;
  assign unused_par = ^{PAR_BITS'(0)};
endmodule

// File: rtl/ecc_reg_front_chk.sv
module ecc_reg_front_chk
  import ecc_front_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CTL_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [31:0]       status_q,
  input logic              evt_enc_done,
  input logic              evt_dec_done
);
  assert_init_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_INIT] |=> !ctrl_q[CB_INIT]);

  assert_init_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_INIT] |=> byte_cnt == '0);

  assert_disabled_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_DATA) && !ctrl_q[CB_EN] && !ctrl_q[CB_INIT])
      |=> $stable(byte_cnt));

  assert_enc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enc_done |=> status_q[ST_ENCD]);

  assert_dec_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dec_done |=> status_q[ST_DECD]);

  assert_zero_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_ZERO]) |-> status_q[ST_DECD]);

  assert_ones_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_ONES]) |-> status_q[ST_DECD]);
endmodule

bind ecc_reg_front ecc_reg_front_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .ctrl_q(ctrl_q), .byte_cnt(byte_cnt), .status_q(status_q),
  .evt_enc_done(evt_enc_done), .evt_dec_done(evt_dec_done)
);

// File: tb/ecc_reg_front_bench.sv
module ecc_reg_front_bench;
  localparam int CLK_P = 10;
  localparam int PW    = 4;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_we = 0;
  logic [7:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic [127:0] par_words_i = 128'h4444_4443_3333_3332_2222_2221_1111_1110;
  logic         res_err_i = 0, res_uncor_i = 0;
  logic [6:0]   res_total_i = 0;
  logic [3:0]   res_count_i = 0;
  logic         cdc_en, cdc_init, cdc_strong, cdc_encode, cdc_byte_vld;
  logic [7:0]   cdc_byte;

  int total = 0, bad = 0;

  ecc_reg_front #(.ADDR_W(8), .CNT_W(10), .PAR_WORDS(PW)) u_ecc_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_words_i(par_words_i),
    .res_err_i(res_err_i), .res_uncor_i(res_uncor_i), .res_total_i(res_total_i),
    .res_count_i(res_count_i), .cdc_en(cdc_en), .cdc_init(cdc_init),
    .cdc_strong(cdc_strong), .cdc_encode(cdc_encode),
    .cdc_byte_vld(cdc_byte_vld), .cdc_byte(cdc_byte)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ctrl = 0, m_enc = 0, m_dec = 0, m_seen = 0;
  int unsigned m_stat = 0;
  bit m_all0 = 1, m_allf = 1;

  function automatic int unsigned model_read(int a);
    if (a == 'h00) return m_ctrl;
    if (a == 'h0C) return (m_dec << 16) | m_enc;
    if (a == 'h24) return m_stat;
    for (int i = 0; i < PW; i++)
      if (a == 'h14 + 4*i) return par_words_i[32*i +: 32];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_enc = 0; m_dec = 0; m_seen = 0; m_stat = 0; m_all0 = 1; m_allf = 1;
    end else begin
      bit in_init, take;
      int b;
      in_init = (m_ctrl & 2) != 0;
      b = bus_wdata[7:0];
      take = bus_we && bus_addr == 'h10 && (m_ctrl & 1) != 0 && !in_init;
      if (bus_we && bus_addr == 'h24) m_stat = m_stat & ~bus_wdata;
      if (in_init) begin
        m_seen = 0; m_all0 = 1; m_allf = 1; m_stat = 0;
      end else if (take) begin
        m_seen = (m_seen + 1) % 1024;
        m_all0 = m_all0 && b == 0;
        m_allf = m_allf && b == 255;
        if ((m_ctrl & 8) != 0 && m_seen == m_enc) m_stat = m_stat | 4;
        if ((m_ctrl & 8) == 0 && m_seen == m_dec) begin
          m_stat = m_stat | 8 | (m_all0 ? 32 : 0) | (m_allf ? 16 : 0)
                 | (res_err_i ? 1 : 0) | (res_uncor_i ? 2 : 0)
                 | (int'(res_total_i) << 16) | (int'(res_count_i) << 28);
        end
      end
      if (bus_we && bus_addr == 'h04) m_ctrl = m_ctrl | (bus_wdata & 'hF);
      if (bus_we && bus_addr == 'h08) m_ctrl = m_ctrl & ~(bus_wdata & 'hF);
      if (in_init) m_ctrl = m_ctrl & ~2;
      if (bus_we && bus_addr == 'h0C) begin
        m_enc = bus_wdata[9:0]; m_dec = bus_wdata[25:16];
      end
    end
    #(CLK_P/4);
    begin
      string tag;
      tag = (bus_addr == 'h00) ? "R2" : (bus_addr == 'h0C) ? "R3" :
            (bus_addr == 'h24) ? "R7" : "R10";
      check({tag, " model rdata"}, bus_rdata, model_read(int'(bus_addr)));
      check("R2 model codec ctrl", {28'h0, cdc_encode, cdc_strong, cdc_init, cdc_en},
            m_ctrl);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    bus_we = 0; bus_addr = 8'(a);
    #1 v = bus_rdata;
  endtask

  task automatic push(logic [7:0] b, bit expect_take);
    @(negedge clk);
    bus_we = 1; bus_addr = 8'h10; bus_wdata = {24'hABCDEF, b};
    #1;
    check("R5 byte valid", 32'(cdc_byte_vld), 32'(expect_take));
    if (expect_take) check("R5 byte value", 32'(cdc_byte), 32'(b));
    @(negedge clk);
    bus_we = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd('h00, v); check("R1 ctrl after reset", v, 0);
    rd('h0C, v); check("R1 count after reset", v, 0);
    rd('h24, v); check("R1 status after reset", v, 0);

    // R2 aliases
    wr('h00, 'hF); rd('h00, v); check("R2 plain write ignored", v, 0);
    wr('h04, 'h5); rd('h00, v); check("R2 set alias", v, 'h5);
    check("R2 strong output", 32'(cdc_strong), 1);
    wr('h08, 'h4); rd('h00, v); check("R2 clear alias", v, 'h1);

    // R3 counts
    wr('h0C, 'hFFFF_FFFF); rd('h0C, v); check("R3 field widths", v, 'h03FF_03FF);
    wr('h0C, 'h0002_0001); rd('h0C, v); check("R3 readback", v, 'h0002_0001);

    // R11 disabled stream, then R6
    wr('h08, 'h1); wr('h04, 'hA);
    rd('h00, v); check("R4 init self-clears", v, 'h8);
    push(8'h12, 0); rd('h24, v); check("R11 disabled byte ignored", v, 0);
    wr('h04, 'h1); push(8'h34, 1);
    rd('h24, v); check("R6 encode done on first byte", v, 'h4);
    wr('h24, 'h1); rd('h24, v); check("R9 unrelated bit kept", v, 'h4);
    wr('h24, 'h4); rd('h24, v); check("R9 flag cleared", v, 0);

    // R6 longer encode
    wr('h0C, 'h0006_0004); wr('h04, 'h2);
    for (int i = 0; i < 3; i++) push(8'(i + 1), 1);
    rd('h24, v); check("R6 not yet done", v, 0);
    push(8'h99, 1); rd('h24, v); check("R6 done at target", v, 'h4);

    // R7 decode with verdict
    res_err_i = 1; res_total_i = 3; res_count_i = 2;
    wr('h08, 'h8); wr('h04, 'h2);
    rd('h24, v); check("R4 init clears status", v, 0);
    for (int i = 0; i < 5; i++) push(8'h11 * 8'(i + 1), 1);
    rd('h24, v); check("R7 not yet done", v, 0);
    push(8'h66, 1); rd('h24, v); check("R7 decode verdict", v, 'h2003_0009);

    // R8 all zero
    res_err_i = 0; res_total_i = 0; res_count_i = 0;
    wr('h04, 'h2);
    for (int i = 0; i < 6; i++) push(8'h00, 1);
    rd('h24, v); check("R8 all zero", v, 'h28);
    wr('h24, 'h8); rd('h24, v); check("R9 partial clear", v, 'h20);
    wr('h24, v); rd('h24, v); check("R9 write back read value", v, 0);

    // R8 all ones
    wr('h04, 'h2);
    for (int i = 0; i < 6; i++) push(8'hFF, 1);
    rd('h24, v); check("R8 all ones", v, 'h18);

    // R8 mixed blank bytes, with uncorrectable verdict
    res_uncor_i = 1;
    wr('h04, 'h2);
    for (int i = 0; i < 6; i++) push((i % 2) ? 8'hFF : 8'h00, 1);
    rd('h24, v); check("R8 mixed not blank, R7 uncorrectable", v, 'hA);
    res_uncor_i = 0;

    // R4 init restarts the count mid-stream
    wr('h04, 'h2);
    for (int i = 0; i < 3; i++) push(8'h5A, 1);
    wr('h04, 'h2);
    for (int i = 0; i < 5; i++) push(8'h5A, 1);
    rd('h24, v); check("R4 counter restarted", v, 0);
    push(8'h5A, 1); rd('h24, v); check("R4 done after full count", v, 'h8);

    // R10 parity words
    for (int i = 0; i < PW; i++) begin
      rd('h14 + 4*i, v); check("R10 parity word", v, par_words_i[32*i +: 32]);
    end
    par_words_i[7:0] = 8'hC3;
    rd('h14, v); check("R10 first byte in LSB", 32'(v[7:0]), 'hC3);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule